// File: doc/BRIEF.md
# Timed Access Write Protection Unit

This unit stands between a register write bus and a set of guarded control bits. Software opens a short write window by storing a two-byte key into a dedicated unlock register. The first byte is `AAh` and the second is `55h`, and the two writes must fall on back-to-back machine cycles. While the window is open, writes that the bus decoder marks as aimed at guarded bits pass through as a gated write strobe. At all other times those writes are blocked and leave the guarded bits unchanged.

A machine cycle is a clock cycle in which `mc_en_i` is high, and writes only count on such cycles. The window covers exactly three machine cycles. Clock cycles with `mc_en_i` low neither use up nor close the window. The unlock register holds no data, so a read of it returns zero. The guarded registers themselves and the bus decoder sit outside this unit.

Top module: `ta_guard`

## Requirements
- R1: While reset is asserted, and after reset until a valid unlock, `prot_ok_o` and `prot_wr_o` are 0. Asserting reset during an open window closes it at once.
- R2: A machine-cycle write of `AAh` to address `TA_ADDR` (default `C7h`), followed on the very next machine cycle by a write of `55h` to the same address, opens the window.
- R3: The window is open (`prot_ok_o`=1) for exactly the three machine cycles that follow the `55h` write. It closes after the third. Clock cycles with `mc_en_i`=0 do not count toward the three.
- R4: When the window is closed, a write with `prot_sel_i`=1 gives `prot_wr_o`=0.
- R5: When the window is open, a machine-cycle write with `prot_sel_i`=1 gives `prot_wr_o`=1 in the same cycle, and it does not shorten the window.
- R6: After `AAh`, the sequence returns to idle and no window opens if the next machine cycle carries any of the following: a write of a value other than `55h` or `AAh` to `TA_ADDR`, a write to another address, or no write at all.
- R7: A machine-cycle write of `AAh` to `TA_ADDR` always restarts the sequence at its first step. A following `55h` then opens the window, and an open window closes on the `AAh` write.
- R8: A `55h` write to `TA_ADDR` that does not directly follow an `AAh` write opens nothing.
- R9: `ta_rdata_o` (the read value of the unlock register) is always `00h`.
- R10: Writes of `AAh` or `55h` to any address other than `TA_ADDR` neither advance the sequence nor close an open window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mc_en_i | input | 1 | Machine-cycle enable |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | ADDR_W (8) | Bus write address |
| wr_data_i | input | DATA_W (8) | Bus write data |
| prot_sel_i | input | 1 | Decoder flag: current write targets guarded bits |
| ta_rdata_o | output | DATA_W (8) | Read value of the unlock register, always zero |
| prot_ok_o | output | 1 | Guarded writes currently allowed |
| prot_wr_o | output | 1 | Gated write strobe for guarded registers |

## Verification
A sequencer stuck in its armed state would let a late `55h` open the window. That shows on `prot_ok_o` on the machine cycle right after the offending write. A window counter that loads the wrong value, or that counts idle clocks, moves the closing edge of `prot_ok_o`. The tests therefore probe the cycle just before and the cycle just after the third machine cycle, with and without stall cycles in between. A gate that ignores the window shows as a `prot_wr_o` pulse on any blocked guarded write, in the same cycle as that write.

// File: rtl/ta_pkg.sv
package ta_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE  = 1'b0,
    SEQ_ARMED = 1'b1
  } seq_st_e;
endpackage

// File: rtl/ta_rst_sync.sv
module ta_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/ta_key_decode.sv
module ta_key_decode #(
  parameter int              ADDR_W     = 8,
  parameter int              DATA_W     = 8,
  parameter logic [ADDR_W-1:0] TA_ADDR  = 8'hC7,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55
) (
  input  logic              mc_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              key1_o,
  output logic              key2_o
);
  logic ta_wr;

  // a write to the unlock register only counts on a machine cycle
  always_comb begin
    ta_wr  = mc_en_i & wr_en_i & (wr_addr_i == TA_ADDR);
    key1_o = ta_wr & (wr_data_i == KEY_FIRST);
    key2_o = ta_wr & (wr_data_i == KEY_SECOND);
  end
endmodule

// File: rtl/ta_seq_fsm.sv
module ta_seq_fsm
  import ta_pkg::*;
(
  input  logic clk,
  input  logic rst_sn,
  input  logic mc_en_i,
  input  logic key1_i,
  input  logic key2_i,
  output logic armed_o,
  output logic unlock_o
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    unlock_o = 1'b0;
    if (mc_en_i) begin
      case (st_q)
        SEQ_IDLE: begin
          if (key1_i) st_d = SEQ_ARMED;
        end
        SEQ_ARMED: begin
          if (key2_i) begin
            unlock_o = 1'b1;
            st_d     = SEQ_IDLE;
          end else if (key1_i) begin
            st_d = SEQ_ARMED;
          end else begin
            st_d = SEQ_IDLE;
          end
        end
        default: st_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      st_q <= SEQ_IDLE;
    else if (mc_en_i) st_q <= st_d;
  end

  assign armed_o = (st_q == SEQ_ARMED);

  AST_GAP_ABORTS: assert property (@(posedge clk) disable iff (!rst_sn)
    (armed_o && mc_en_i && !key1_i && !key2_i) |=> !armed_o); // R6
  AST_UNLOCK_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_sn)
    unlock_o |-> armed_o); // R8
  AST_ARMED_SOURCE: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(armed_o) |-> $past(key1_i)); // R7
endmodule

// File: rtl/ta_window.sv
module ta_window #(
  parameter int WIN_CYC = 3,
  localparam int CNT_W = $clog2(WIN_CYC + 1)
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic mc_en_i,
  input  logic unlock_i,
  input  logic restart_i,
  output logic open_o
);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_CYC);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)                        cnt_d = '0;
    else if (unlock_i)                    cnt_d = CNT_LOAD;
    else if (mc_en_i && (cnt_q != '0))    cnt_d = cnt_q - CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      cnt_q <= '0;
    else if (mc_en_i) cnt_q <= cnt_d;
  end

  assign open_o = (cnt_q != '0);

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_sn)
    cnt_q <= CNT_LOAD); // R3
  AST_WIN_LAST: assert property (@(posedge clk) disable iff (!rst_sn)
    (mc_en_i && cnt_q == CNT_ONE && !restart_i && !unlock_i) |=> !open_o); // R3
  AST_WIN_STALL: assert property (@(posedge clk) disable iff (!rst_sn)
    !mc_en_i |=> $stable(cnt_q)); // R3
  AST_RESTART_CLOSES: assert property (@(posedge clk) disable iff (!rst_sn)
    restart_i |=> !open_o); // R7
endmodule

// File: rtl/ta_guard.sv
module ta_guard #(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] TA_ADDR    = 8'hC7,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55,
  parameter int                WIN_CYC    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              prot_sel_i,
  output logic [DATA_W-1:0] ta_rdata_o,
  output logic              prot_ok_o,
  output logic              prot_wr_o
);
  logic rst_sn;
  logic key1, key2;
  logic armed, unlock;
  logic win_open;

  ta_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  ta_key_decode #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .TA_ADDR    (TA_ADDR),
    .KEY_FIRST  (KEY_FIRST),
    .KEY_SECOND (KEY_SECOND)
  ) u_dec (
    .mc_en_i   (mc_en_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .key1_o    (key1),
    .key2_o    (key2)
  );

  ta_seq_fsm u_seq (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .mc_en_i  (mc_en_i),
    .key1_i   (key1),
    .key2_i   (key2),
    .armed_o  (armed),
    .unlock_o (unlock)
  );

  ta_window #(
    .WIN_CYC (WIN_CYC)
  ) u_win (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .mc_en_i   (mc_en_i),
    .unlock_i  (unlock),
    .restart_i (key1),
    .open_o    (win_open)
  );

  assign prot_ok_o  = win_open & rst_sn;
  assign prot_wr_o  = prot_ok_o & mc_en_i & wr_en_i & prot_sel_i;
  assign ta_rdata_o = '0;

  AST_GATE_NEEDS_WIN: assert property (@(posedge clk) disable iff (!rst_sn)
    prot_wr_o |-> prot_ok_o); // R4
  AST_OPEN_CAUSE: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(prot_ok_o) |-> $past(mc_en_i && wr_en_i && wr_addr_i == TA_ADDR
                               && wr_data_i == KEY_SECOND && armed)); // R2
  AST_PROT_KEEPS_WIN: assert property (@(posedge clk) disable iff (!rst_sn)
    (prot_wr_o && !key1 && u_win.cnt_q > 1) |=> prot_ok_o); // R5
  AST_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    ta_rdata_o == '0); // R9
endmodule

// File: tb/ta_guard_tb_top.sv
module ta_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mc_en, wr_en, prot_sel;
  logic [7:0] wr_addr, wr_data;
  logic [7:0] ta_rdata;
  logic       prot_ok, prot_wr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  localparam logic [7:0] TA = 8'hC7;

  always #5 clk = ~clk;

  ta_guard dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mc_en_i    (mc_en),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .prot_sel_i (prot_sel),
    .ta_rdata_o (ta_rdata),
    .prot_ok_o  (prot_ok),
    .prot_wr_o  (prot_wr)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // one clock cycle, inputs driven at the falling edge
  task automatic step(input logic mc, input logic wr, input logic [7:0] a,
                      input logic [7:0] d, input logic ps);
    @(negedge clk);
    mc_en = mc; wr_en = wr; wr_addr = a; wr_data = d; prot_sel = ps;
    #1;
  endtask

  task automatic idle_bus();
    @(negedge clk);
    mc_en = 1'b0; wr_en = 1'b0; wr_addr = 8'h00; wr_data = 8'h00; prot_sel = 1'b0;
  endtask

  // guarded write attempt on a machine cycle, checking window and strobe
  task automatic prot_try(input string req, input logic exp);
    step(1, 1, 8'h90, 8'h5A, 1);
    chk(req, prot_ok, exp);
    chk(req, prot_wr, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle_bus();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic unlock();
    step(1, 1, TA, 8'hAA, 0);
    step(1, 1, TA, 8'h55, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(1, 1, 8'h90, 8'h01, 1);
    chk("R1", prot_ok, 1'b0);
    chk("R1", prot_wr, 1'b0);
    do_reset();
    prot_try("R1", 1'b0);
    chk("R9", ta_rdata == 8'h00, 1'b1);
  endtask

  task automatic t_basic();
    unlock();
    chk("R2", prot_ok, 1'b0);
    prot_try("R2", 1'b1);
    prot_try("R5", 1'b1);
    prot_try("R3", 1'b1);
    prot_try("R3", 1'b0);
    prot_try("R4", 1'b0);
    chk("R9", ta_rdata == 8'h00, 1'b1);
  endtask

  task automatic t_stall();
    unlock();
    for (int i = 0; i < 4; i++) begin
      step(0, 1, 8'h90, 8'h00, 1);
      chk("R3", prot_ok, 1'b1);
      chk("R3", prot_wr, 1'b0);
    end
    prot_try("R3", 1'b1);
    step(0, 0, 8'h00, 8'h00, 0);
    prot_try("R3", 1'b1);
    prot_try("R3", 1'b1);
    prot_try("R3", 1'b0);
  endtask

  task automatic t_abort();
    step(1, 1, TA, 8'hAA, 0);
    step(1, 0, 8'h00, 8'h00, 0);
    step(1, 1, TA, 8'h55, 0);
    prot_try("R6", 1'b0);
    step(1, 1, TA, 8'hAA, 0);
    step(1, 1, TA, 8'h56, 0);
    step(1, 1, TA, 8'h55, 0);
    prot_try("R6", 1'b0);
    step(1, 1, TA, 8'hAA, 0);
    step(1, 1, 8'h90, 8'h00, 1);
    chk("R6", prot_wr, 1'b0);
    step(1, 1, TA, 8'h55, 0);
    prot_try("R6", 1'b0);
    // stall cycles between the two keys are not machine cycles
    step(1, 1, TA, 8'hAA, 0);
    step(0, 0, 8'h00, 8'h00, 0);
    step(1, 1, TA, 8'h55, 0);
    prot_try("R6", 1'b1);
    prot_try("R6", 1'b1);
    prot_try("R6", 1'b1);
    prot_try("R6", 1'b0);
  endtask

  task automatic t_restart();
    step(1, 1, TA, 8'hAA, 0);
    step(1, 1, TA, 8'hAA, 0);
    step(1, 1, TA, 8'h55, 0);
    prot_try("R7", 1'b1);
    step(1, 1, TA, 8'hAA, 0);
    chk("R7", prot_ok, 1'b1);
    prot_try("R7", 1'b0);
    unlock();
    prot_try("R7", 1'b1);
    step(1, 1, TA, 8'hAA, 0);
    step(1, 1, TA, 8'h55, 0);
    prot_try("R7", 1'b1);
    prot_try("R7", 1'b1);
    prot_try("R7", 1'b1);
    prot_try("R7", 1'b0);
  endtask

  task automatic t_lone55();
    step(1, 1, TA, 8'h55, 0);
    prot_try("R8", 1'b0);
    step(1, 1, TA, 8'h55, 0);
    step(1, 1, TA, 8'h55, 0);
    prot_try("R8", 1'b0);
  endtask

  task automatic t_other_addr();
    step(1, 1, 8'hC6, 8'hAA, 0);
    step(1, 1, TA, 8'h55, 0);
    prot_try("R10", 1'b0);
    step(1, 1, TA, 8'hAA, 0);
    step(1, 1, 8'hC6, 8'h55, 0);
    prot_try("R10", 1'b0);
    unlock();
    step(1, 1, 8'hC6, 8'hAA, 0);
    chk("R10", prot_ok, 1'b1);
    prot_try("R10", 1'b1);
    prot_try("R10", 1'b1);
    prot_try("R10", 1'b0);
  endtask

  task automatic t_reset_mid();
    unlock();
    prot_try("R1", 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", prot_ok, 1'b0);
    chk("R1", prot_wr, 1'b0);
    do_reset();
    prot_try("R1", 1'b0);
  endtask

  initial begin
    mc_en = 0; wr_en = 0; wr_addr = 0; wr_data = 0; prot_sel = 0; rst_n = 0;
    t_reset();
    t_basic();
    t_stall();
    t_abort();
    t_restart();
    t_lone55();
    t_other_addr();
    t_reset_mid();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule